// File: doc/BRIEF.md
# Banked Register File Address Unit

This block sits between a small processor core and its data register file. The file is split into up to four banks of 128 byte locations each. On every access the core presents a 7-bit register field taken from the instruction. The block turns that field into an effective 9-bit address, returns the addressed byte combinationally, and commits a write on the next clock edge. The block holds its own bank-control word, its pointer register, three further control registers that every bank shares, and the general-purpose storage of each bank.

Two address paths exist. On the direct path, two bank bits in the bank-control word sit above the 7-bit field. When the field names offset 00h, the indirect path is taken instead. Offset 00h has no storage of its own. The access goes to the location given by the 8-bit pointer, with one more control bit placed above it. A few control registers occupy the same offset in every bank and are each a single physical register. Each bank has its own general-purpose storage at offsets 20h to 7Fh.

Top module: `banked_rf_addr`

## Requirements
- R1: After reset the bank-control word reads 18h. The pointer, the program-counter low byte (offset 02h), the program-counter latch (offset 0Ah) and the interrupt-control register (offset 0Bh) each read 00h.
- R2: When the field is not 00h, `eff_addr` equals {control bit 6, control bit 5, field}. Bit 6 is the upper bank bit and bit 5 the lower bank bit.
- R3: When the field is 00h, `eff_addr` equals {control bit 7, pointer[7:0]}.
- R4: An indirect read returns the byte at the location in `eff_addr`. An indirect write updates that location. This includes a write whose target is the pointer or the control word itself.
- R5: An indirect access whose target offset (eff_addr[6:0]) is 00h reads 00h. A write in that case changes no state.
- R6: Offsets 02h, 03h (control word), 04h (pointer), 0Ah and 0Bh map to one physical register each, whichever bank is selected.
- R7: Offsets 20h to 7Fh hold separate storage in each bank.
- R8: Offsets 01h, 05h–09h and 0Ch–1Fh read 00h, and writes to them are ignored.
- R9: Control bits 4 and 3 come out of reset as 1. The write port cannot change them. A write to the control word loads only bits 7:5 and 2:0.
- R10: `rd_data` follows the current address combinationally. A write takes effect at the clock edge. A control-word or pointer write therefore changes the mapping only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_field | input | 7 | Register field of the current instruction |
| wr_en | input | 1 | Write strobe, committed at the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Byte at the effective location |
| eff_addr | output | 9 | Effective address of the current access |

## Verification
Redirection through the pointer and the update of the pointer or the control word can fall in the same cycle. This happens when an indirect write targets the pointer (its bank-0 offset or any mirror) or the control word. The bench provokes it by sweeping indirect writes across all 512 pointer/control-bit combinations. Before the edge it samples `rd_data` against the old target. After the edge it reads again through offset 00h, and the expected value there follows the updated pointer. A direct write to the control word is also checked in the same way: the old value is visible before the edge and the new bank mapping after it.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
   localparam int unsigned OFF_W  = 7;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 9;

   localparam logic [OFF_W-1:0] OFF_INDIR = 7'h00;
   localparam logic [OFF_W-1:0] OFF_PCLO  = 7'h02;
   localparam logic [OFF_W-1:0] OFF_CTRL  = 7'h03;
   localparam logic [OFF_W-1:0] OFF_PTR   = 7'h04;
   localparam logic [OFF_W-1:0] OFF_PCHI  = 7'h0A;
   localparam logic [OFF_W-1:0] OFF_IRQC  = 7'h0B;

   localparam int unsigned CB_XBANK = 7;
   localparam int unsigned CB_BK1   = 6;
   localparam int unsigned CB_BK0   = 5;
   localparam int unsigned CB_TMO   = 4;
   localparam int unsigned CB_PWD   = 3;

   localparam logic [DATA_W-1:0] CTRL_RST = 8'h18;
   localparam logic [DATA_W-1:0] CTRL_WMASK = 8'hE7;

   typedef struct packed {
      logic              indirect;
      logic              null_hit;
      logic [1:0]        bank;
      logic [OFF_W-1:0]  off;
   } rfa_target_t;
endpackage

// File: rtl/rfa_addr_gen.sv
module rfa_addr_gen
   import rfa_pkg::*;
(
   input  logic [OFF_W-1:0]  field,
   input  logic [DATA_W-1:0] ctrl,
   input  logic [DATA_W-1:0] ptr,
   output rfa_target_t       tgt,
   output logic [ADDR_W-1:0] eff
);
   logic is_ind;

   always_comb begin
      is_ind = (field == OFF_INDIR);
      if (is_ind)
         eff = {ctrl[CB_XBANK], ptr};
      else
         eff = {ctrl[CB_BK1], ctrl[CB_BK0], field};
      tgt.indirect = is_ind;
      tgt.bank     = eff[ADDR_W-1:OFF_W];
      tgt.off      = eff[OFF_W-1:0];
      tgt.null_hit = is_ind && (eff[OFF_W-1:0] == OFF_INDIR);
   end
endmodule

// File: rtl/rfa_sfr_file.sv
module rfa_sfr_file
   import rfa_pkg::*;
#(
   parameter int unsigned GPR_BASE = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFF_W-1:0]  off,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] ptr_q
);
   logic [DATA_W-1:0] pclo_q, pchi_q, irqc_q;
   logic              wr_sfr;

   assign wr_sfr = wr_en && (32'(off) < GPR_BASE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         ptr_q  <= '0;
         pclo_q <= '0;
         pchi_q <= '0;
         irqc_q <= '0;
      end else if (wr_sfr) begin
         case (off)
            OFF_CTRL: ctrl_q <= (wr_data & CTRL_WMASK) | (ctrl_q & ~CTRL_WMASK);
            OFF_PTR:  ptr_q  <= wr_data;
            OFF_PCLO: pclo_q <= wr_data;
            OFF_PCHI: pchi_q <= wr_data;
            OFF_IRQC: irqc_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (off)
         OFF_CTRL: rd_data = ctrl_q;
         OFF_PTR:  rd_data = ptr_q;
         OFF_PCLO: rd_data = pclo_q;
         OFF_PCHI: rd_data = pchi_q;
         OFF_IRQC: rd_data = irqc_q;
         default:  rd_data = '0;
      endcase
   end

   // R10
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sfr && off == OFF_PTR) |=> (ptr_q == $past(wr_data)));

   // R9
   ctrl_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sfr && off == OFF_CTRL) |=> (ctrl_q[CB_TMO] && ctrl_q[CB_PWD]));

   // R9
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sfr && off == OFF_CTRL) |=> (ctrl_q[CB_XBANK:CB_BK0] == $past(wr_data[7:5])));
endmodule

// File: rtl/rfa_gpr_banks.sv
module rfa_gpr_banks
   import rfa_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned GPR_BASE  = 32
)(
   input  logic              clk,
   input  logic [1:0]        bank,
   input  logic [OFF_W-1:0]  off,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              in_gpr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH  = (1 << OFF_W) - GPR_BASE;
   localparam int unsigned IDX_W  = $clog2(DEPTH);
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   logic [IDX_W-1:0]  idx;
   logic [BANK_W-1:0] bsel;
   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   assign in_gpr = (32'(off) >= GPR_BASE);
   assign idx    = in_gpr ? IDX_W'(32'(off) - GPR_BASE) : '0;
   assign bsel   = bank[BANK_W-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && in_gpr && bsel == BANK_W'(b))
            mem[idx] <= wr_data;
      end
      assign bank_rd[b] = mem[idx];
   end

   assign rd_data = bank_rd[bsel];
endmodule

// File: rtl/banked_rf_addr.sv
module banked_rf_addr
   import rfa_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned GPR_BASE  = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [6:0]   dir_field,
   input  logic         wr_en,
   input  logic [7:0]   wr_data,
   output logic [7:0]   rd_data,
   output logic [8:0]   eff_addr
);
   if (NUM_BANKS != 2 && NUM_BANKS != 4) begin : g_bad_banks
      $error("banked_rf_addr: NUM_BANKS must be 2 or 4");
   end
   if (GPR_BASE <= 32'(OFF_IRQC) || GPR_BASE >= (1 << OFF_W)) begin : g_bad_base
      $error("banked_rf_addr: GPR_BASE must lie above the shared registers");
   end

   rfa_target_t       tgt;
   logic [DATA_W-1:0] ctrl, ptr, sfr_rd, gpr_rd;
   logic              in_gpr, wr_ok;

   rfa_addr_gen u_agen (
      .field (dir_field),
      .ctrl  (ctrl),
      .ptr   (ptr),
      .tgt   (tgt),
      .eff   (eff_addr)
   );

   assign wr_ok = wr_en && !tgt.null_hit;

   rfa_sfr_file #(.GPR_BASE(GPR_BASE)) u_sfr (
      .clk     (clk),
      .rst_n   (rst_n),
      .off     (tgt.off),
      .wr_en   (wr_ok),
      .wr_data (wr_data),
      .rd_data (sfr_rd),
      .ctrl_q  (ctrl),
      .ptr_q   (ptr)
   );

   rfa_gpr_banks #(.NUM_BANKS(NUM_BANKS), .GPR_BASE(GPR_BASE)) u_gpr (
      .clk     (clk),
      .bank    (tgt.bank),
      .off     (tgt.off),
      .wr_en   (wr_ok),
      .wr_data (wr_data),
      .in_gpr  (in_gpr),
      .rd_data (gpr_rd)
   );

   always_comb begin
      if (tgt.null_hit)
         rd_data = '0;
      else if (in_gpr)
         rd_data = gpr_rd;
      else
         rd_data = sfr_rd;
   end

   // R2
   direct_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_field != 7'h00) |-> (eff_addr == {ctrl[6:5], dir_field}));

   // R3
   indirect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_field == 7'h00) |-> (eff_addr == {ctrl[7], ptr}));

   // R5
   null_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_field == 7'h00 && ptr[6:0] == 7'h00) |-> (rd_data == 8'h00));

   // R5
   null_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_field == 7'h00 && ptr[6:0] == 7'h00 && wr_en) |=> ($stable(ptr) && $stable(ctrl)));
endmodule

// File: tb/tb_banked_rf_addr.sv
module tb_banked_rf_addr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] dir_field = 7'h01;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [8:0] eff_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] m_ctrl, m_ptr, m_pclo, m_pchi, m_irqc;
   logic [7:0] m_gpr [4][96];

   always #4 clk = ~clk;

   banked_rf_addr dut (
      .clk(clk), .rst_n(rst_n), .dir_field(dir_field), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .eff_addr(eff_addr)
   );

   function automatic logic [8:0] m_eff(input logic [6:0] a);
      if (a == 7'h00) return {m_ctrl[7], m_ptr};
      return {m_ctrl[6:5], a};
   endfunction

   function automatic logic [7:0] m_read(input logic [6:0] a);
      logic [8:0] e;
      int off;
      e = m_eff(a);
      off = int'(e[6:0]);
      if (off == 0) return 8'h00;
      if (off >= 32) return m_gpr[e[8:7]][off-32];
      case (off)
         2: return m_pclo;
         3: return m_ctrl;
         4: return m_ptr;
         10: return m_pchi;
         11: return m_irqc;
         default: return 8'h00;
      endcase
   endfunction

   task automatic m_write(input logic [6:0] a, input logic [7:0] d);
      logic [8:0] e;
      int off;
      e = m_eff(a);
      off = int'(e[6:0]);
      if (off >= 32) m_gpr[e[8:7]][off-32] = d;
      else case (off)
         2: m_pclo = d;
         3: m_ctrl = {d[7:5], m_ctrl[4:3], d[2:0]};
         4: m_ptr = d;
         10: m_pchi = d;
         11: m_irqc = d;
         default: ;
      endcase
   endtask

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [6:0] a);
      logic [6:0] o;
      o = m_eff(a)[6:0];
      if (a == 7'h00 && o == 7'h00) return "R5";
      if (a == 7'h00) return "R4";
      if (o >= 7'h20) return "R7";
      if (o == 7'h02 || o == 7'h03 || o == 7'h04 || o == 7'h0A || o == 7'h0B) return "R6";
      return "R8";
   endfunction

   task automatic rd_chk(input logic [6:0] a);
      @(negedge clk);
      dir_field = a;
      wr_en = 1'b0;
      #2;
      check(tag_of(a), {1'b0, rd_data}, {1'b0, m_read(a)});
      check((a == 7'h00) ? "R3" : "R2", eff_addr, m_eff(a));
   endtask

   // writes; before the edge the old value must still be visible (R10)
   task automatic wr(input logic [6:0] a, input logic [7:0] d, input bit pre);
      @(negedge clk);
      dir_field = a;
      wr_data = d;
      wr_en = 1'b1;
      #2;
      if (pre) check("R10", {1'b0, rd_data}, {1'b0, m_read(a)});
      m_write(a, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_ctrl = 8'h18; m_ptr = 8'h00; m_pclo = 8'h00; m_pchi = 8'h00; m_irqc = 8'h00;
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 96; i++) m_gpr[b][i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_chk(7'h03); rd_chk(7'h04); rd_chk(7'h02); rd_chk(7'h0A); rd_chk(7'h0B);
      check("R1", {1'b0, rd_data}, 9'h000);

      // fill every bank; the fill itself defines model contents (R7)
      for (int b = 0; b < 4; b++) begin
         wr(7'h03, 8'(b << 5), 1'b0);
         for (int o = 32; o < 128; o++) wr(7'(o), 8'((b * 97 + o) ^ 8'h5A), 1'b0);
      end
      // shared registers written from bank 2 (R6), junk to holes (R8), R9
      wr(7'h03, 8'h40, 1'b1);
      wr(7'h02, 8'h11, 1'b1); wr(7'h0A, 8'h1A, 1'b1); wr(7'h0B, 8'hB1, 1'b1);
      wr(7'h04, 8'h3C, 1'b1);
      wr(7'h03, 8'h60, 1'b1);
      for (int o = 1; o < 32; o++)
         if (!(o == 2 || o == 3 || o == 4 || o == 10 || o == 11)) wr(7'(o), 8'hFF, 1'b1);
      wr(7'h03, 8'h00, 1'b1);
      rd_chk(7'h03);
      check("R9", {1'b0, rd_data}, 9'h018);

      // direct sweep of every offset in every bank (R2, R6, R7, R8)
      for (int b = 0; b < 4; b++) begin
         wr(7'h03, 8'((b << 5) | 7), 1'b1);
         for (int o = 1; o < 128; o++) rd_chk(7'(o));
      end

      // indirect read sweep over all 512 targets (R3, R4, R5)
      for (int x = 0; x < 2; x++) begin
         wr(7'h03, 8'(x << 7), 1'b1);
         for (int p = 0; p < 256; p++) begin
            wr(7'h04, 8'(p), 1'b1);
            rd_chk(7'h00);
         end
      end

      // indirect write sweep incl. self-targeting pointer/control (R4, R5, R10)
      for (int x = 0; x < 2; x++) begin
         for (int p = 0; p < 256; p++) begin
            wr(7'h03, 8'(x << 7), 1'b1);
            wr(7'h04, 8'(p), 1'b1);
            wr(7'h00, 8'(p ^ 8'hC3), 1'b1);
            rd_chk(7'h00);
            rd_chk(7'h04);
         end
      end

      // null indirect write leaves state untouched (R5)
      wr(7'h03, 8'h80, 1'b1);
      wr(7'h04, 8'h80, 1'b1);
      wr(7'h00, 8'h77, 1'b1);
      rd_chk(7'h00);
      check("R5", {1'b0, rd_data}, 9'h000);
      rd_chk(7'h03); rd_chk(7'h04); rd_chk(7'h02);

      // bank switch visible only from the next cycle (R10)
      wr(7'h03, 8'h60, 1'b1);
      rd_chk(7'h25);
      check("R10", eff_addr, 9'h1A5);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule